// File: doc/BRIEF.md
# Soft Interrupt Pending Register with Tick-Compare Timers

This block keeps a small register of software-visible pending interrupt bits and two 64-bit compare registers that watch an externally supplied, free-running system tick count. Software changes the pending bits in one of three ways. It can overwrite them, OR new bits in through a set alias, or knock bits out through a clear alias. Every such write tells the surrounding core to look at its interrupt state again, through a one-cycle recheck pulse.

Each compare register uses its most significant bit as a disable flag. Its remaining 63 bits are matched against the low 63 bits of the tick count. A compare is armed only by a write that is enabled and that names a tick still in the future. It fires once, on the cycle of equality, and then disarms. The system compare also sets a fixed pending bit. The hypervisor-level compare only raises the recheck pulse. Interrupt delivery, trap entry and priority arbitration belong to other blocks.

Top module: `swint_tick_timer`

## Requirements
- R1: Out of reset the pending bits and the recheck output are zero, and both compare registers read back as 0x8000_0000_0000_0000 (disabled, value zero).
- R2: A write to address 0 replaces the pending bits with the low PEND_W (17) bits of the write data and ignores higher bits. A read of address 0, 1 or 2 returns the pending bits zero-extended to 64 bits.
- R3: A write to address 1 (set alias) stores the old pending bits ORed with the written data.
- R4: A write to address 2 (clear alias) stores the old pending bits ANDed with the complement of the written data.
- R5: Any write to address 0, 1 or 2 drives recheck high for exactly the one cycle that follows the write edge.
- R6: Address 3 (system compare) and address 4 (hypervisor compare) store all 64 written bits, and a read returns them unchanged.
- R7: Bit 63 of a compare register set means disabled. A match compares bits 62:0 of the register with bits 62:0 of the tick input and ignores tick bit 63.
- R8: A compare write arms a match only when bit 63 is clear and bits 62:0 are strictly greater than tick bits 62:0 in the write cycle. Any compare write cancels the match armed by the previous value.
- R9: When the armed system compare equals the tick, pending bit 16 is set and recheck pulses in the next cycle. This happens once per arming.
- R10: When the armed hypervisor compare equals the tick, recheck pulses in the next cycle and the pending bits are left unchanged.
- R11: If a system match and a pending write fall in the same cycle, the write is applied first and bit 16 is then set on top of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register select: 0 pending, 1 set alias, 2 clear alias, 3 system compare, 4 hypervisor compare |
| wr_data | input | 64 | Write data |
| rd_data | output | 64 | Combinational read data for addr |
| tick | input | 64 | Free-running system tick count |
| pending | output | 17 | Pending soft-interrupt bits |
| recheck | output | 1 | One-cycle request to re-evaluate interrupts |

## Verification
A stuck or stale arming flag shows at the ports in one of two ways. Either the recheck pulse is missing on the cycle after the tick reaches the compare value, or an extra pulse appears for a disabled, past or replaced value. The bench therefore counts recheck pulses over whole tick runs, not just at the expected cycle. A wrong alias update is seen on read-back and on the pending output one cycle after the write. A lost match priority shows as bit 16 missing right after a clearing write that coincides with the match.

// File: rtl/swtmr_pkg.sv
package swtmr_pkg;
   typedef enum logic [2:0] {
      A_PEND   = 3'd0,
      A_PSET   = 3'd1,
      A_PCLR   = 3'd2,
      A_SYSCMP = 3'd3,
      A_HYPCMP = 3'd4
   } swtmr_addr_e;

   localparam int unsigned NUM_CMP = 2;
   localparam int unsigned CMP_SYS = 0;
   localparam int unsigned CMP_HYP = 1;
endpackage

// File: rtl/swtmr_pend.sv
module swtmr_pend #(
   parameter int unsigned PEND_W    = 17,
   parameter int unsigned MATCH_BIT = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_direct,
   input  logic              wr_set,
   input  logic              wr_clr,
   input  logic [PEND_W-1:0] wdata,
   input  logic              match_set,
   output logic [PEND_W-1:0] pend_q
);
   logic [PEND_W-1:0] base_v;
   logic [PEND_W-1:0] pend_nxt;

   always_comb begin
      base_v = pend_q;
      if (wr_direct)   base_v = wdata;
      else if (wr_set) base_v = pend_q | wdata;
      else if (wr_clr) base_v = pend_q & ~wdata;
      pend_nxt = base_v;
      if (match_set) pend_nxt[MATCH_BIT] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= pend_nxt;
   end

   // R3
   set_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_set && !wr_direct |=> (pend_q & $past(wdata)) == $past(wdata));
   // R4
   clr_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_clr && !wr_direct && !wr_set && !match_set |=> (pend_q & $past(wdata)) == '0);
   // R11
   match_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      match_set |=> pend_q[MATCH_BIT]);
endmodule

// File: rtl/swtmr_cmp.sv
module swtmr_cmp #(
   parameter int unsigned DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-2:0] tick_lo,
   output logic [DATA_W-1:0] cmp_q,
   output logic              fire
);
   localparam int unsigned VAL_W = DATA_W - 1;

   logic armed_q;
   logic eq;
   logic arm_new;

   assign eq      = (cmp_q[VAL_W-1:0] == tick_lo);
   assign fire    = armed_q && eq && !wr;
   assign arm_new = !wdata[DATA_W-1] && (wdata[VAL_W-1:0] > tick_lo);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmp_q   <= {1'b1, {VAL_W{1'b0}}};
         armed_q <= 1'b0;
      end else if (wr) begin
         cmp_q   <= wdata;
         armed_q <= arm_new;
      end else if (fire) begin
         armed_q <= 1'b0;
      end
   end

   // R7
   disabled_unarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed_q |-> !cmp_q[DATA_W-1]);
   // R9
   fire_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> !fire);
   // R8
   cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr && wdata[DATA_W-1] |=> !fire);
endmodule

// File: rtl/swint_tick_timer.sv
module swint_tick_timer
   import swtmr_pkg::*;
#(
   parameter int unsigned DATA_W    = 64,
   parameter int unsigned PEND_W    = 17,
   parameter int unsigned MATCH_BIT = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   input  logic [DATA_W-1:0] tick,
   output logic [PEND_W-1:0] pending,
   output logic              recheck
);
   generate
      if (MATCH_BIT >= PEND_W) begin : g_bad_bit
         $error("MATCH_BIT must lie inside the pending register");
      end
      if (PEND_W > DATA_W) begin : g_bad_pend
         $error("PEND_W must not exceed DATA_W");
      end
      if (DATA_W < 2) begin : g_bad_data
         $error("DATA_W needs a flag bit and a value");
      end
   endgenerate

   logic              wr_direct, wr_set, wr_clr, wr_pend_any;
   logic [NUM_CMP-1:0] fire_v;
   logic [DATA_W-1:0] cmp_q [NUM_CMP];
   logic              recheck_q;

   assign wr_direct   = wr_en && (addr == A_PEND);
   assign wr_set      = wr_en && (addr == A_PSET);
   assign wr_clr      = wr_en && (addr == A_PCLR);
   assign wr_pend_any = wr_direct || wr_set || wr_clr;

   swtmr_pend #(.PEND_W(PEND_W), .MATCH_BIT(MATCH_BIT)) u_pend (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_direct (wr_direct),
      .wr_set    (wr_set),
      .wr_clr    (wr_clr),
      .wdata     (wr_data[PEND_W-1:0]),
      .match_set (fire_v[CMP_SYS]),
      .pend_q    (pending)
   );

   for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
      localparam logic [2:0] CADDR = (i == CMP_SYS) ? A_SYSCMP : A_HYPCMP;
      logic cwr;
      assign cwr = wr_en && (addr == CADDR);
      swtmr_cmp #(.DATA_W(DATA_W)) u_cmp (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr      (cwr),
         .wdata   (wr_data),
         .tick_lo (tick[DATA_W-2:0]),
         .cmp_q   (cmp_q[i]),
         .fire    (fire_v[i])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) recheck_q <= 1'b0;
      else        recheck_q <= wr_pend_any || (|fire_v);
   end
   assign recheck = recheck_q;

   always_comb begin
      case (addr)
         A_PEND, A_PSET, A_PCLR: rd_data = DATA_W'(pending);
         A_SYSCMP:               rd_data = cmp_q[CMP_SYS];
         A_HYPCMP:               rd_data = cmp_q[CMP_HYP];
         default:                rd_data = '0;
      endcase
   end

   // R5
   pend_wr_recheck_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_pend_any |=> recheck);
   // R9
   sys_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fire_v[CMP_SYS] |=> pending[MATCH_BIT] && recheck);
   // R10
   hyp_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fire_v[CMP_HYP] && !fire_v[CMP_SYS] && !wr_pend_any |=> recheck && $stable(pending));
endmodule

// File: tb/swint_tick_timer_tb.sv
module swint_tick_timer_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  addr = '0;
   logic [63:0] wr_data = '0;
   logic [63:0] rd_data;
   logic [63:0] tick = 64'd100;
   logic [16:0] pending;
   logic        recheck;

   int checks = 0;
   int failures = 0;
   int rc = 0;

   always #5 clk = ~clk;

   swint_tick_timer u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
      .rd_data(rd_data), .tick(tick), .pending(pending), .recheck(recheck)
   );

   localparam int NV = 7;
   localparam logic [2:0]  V_ADDR [NV] = '{3'd0, 3'd1, 3'd2, 3'd0, 3'd1, 3'd2, 3'd0};
   localparam logic [63:0] V_DATA [NV] = '{64'h12345, 64'h00F00, 64'h10005, 64'h0,
                                           64'h1FFFF, 64'hFFFF_0000_0000_0001,
                                           64'hABCD_0000_0000_0003};
   localparam logic [16:0] V_EXP  [NV] = '{17'h12345, 17'h12F45, 17'h02F40, 17'h0,
                                           17'h1FFFF, 17'h1FFFE, 17'h00003};

   task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [2:0] a, logic [63:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic run_to(logic [63:0] v);
      rc = 0;
      while (tick < v) begin
         tick = tick + 1;
         @(negedge clk);
         if (recheck) rc++;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      check("R1 pending", 64'(pending), 64'h0);
      check("R1 recheck", 64'(recheck), 64'h0);
      addr = 3'd3; #1 check("R1 sys cmp", rd_data, 64'h8000_0000_0000_0000);
      addr = 3'd4; #1 check("R1 hyp cmp", rd_data, 64'h8000_0000_0000_0000);

      // R2 R3 R4 R5 vector walk
      for (int i = 0; i < NV; i++) begin
         wr(V_ADDR[i], V_DATA[i]);
         check("R2/R3/R4 pending", 64'(pending), 64'(V_EXP[i]));
         check("R2 readback", rd_data, 64'(V_EXP[i]));
         check("R5 recheck", 64'(recheck), 64'h1);
      end
      @(negedge clk);
      check("R5 single pulse", 64'(recheck), 64'h0);

      // R6 readback of compare registers
      wr(3'd4, 64'hDEAD_BEEF_0123_4567);
      check("R6 hyp readback", rd_data, 64'hDEAD_BEEF_0123_4567);
      check("R6 no recheck on cmp write", 64'(recheck), 64'h0);
      wr(3'd0, 64'h0);

      // R9 system match at tick 103
      wr(3'd3, 64'd103);
      check("R6 sys readback", rd_data, 64'd103);
      run_to(64'd102);
      check("R9 no early fire", 64'(rc), 64'd0);
      run_to(64'd103);
      check("R9 fire recheck", 64'(rc), 64'd1);
      check("R9 pending bit16", 64'(pending), 64'h10000);
      run_to(64'd150);
      check("R9 fires once", 64'(rc), 64'd0);

      // R7 disabled compare
      wr(3'd2, 64'h10000);
      wr(3'd3, 64'h8000_0000_0000_00C8);
      run_to(64'd205);
      check("R7 disabled no fire", 64'(rc), 64'd0);
      check("R7 pending unchanged", 64'(pending), 64'h0);

      // R8 equal or past values do not arm
      tick = 64'd300;
      wr(3'd3, 64'd300);
      run_to(64'd310);
      check("R8 equal not armed", 64'(rc), 64'd0);
      wr(3'd3, 64'd250);
      run_to(64'd320);
      check("R8 past not armed", 64'(rc), 64'd0);

      // R8 rewrite cancels previous arming
      tick = 64'd390;
      wr(3'd3, 64'd400);
      wr(3'd3, 64'd450);
      run_to(64'd449);
      check("R8 cancelled old match", 64'(rc), 64'd0);
      run_to(64'd450);
      check("R8 new match fires", 64'(rc), 64'd1);

      // R10 hypervisor match leaves pending alone
      wr(3'd0, 64'h0);
      tick = 64'd495;
      wr(3'd4, 64'd500);
      run_to(64'd500);
      check("R10 hyp recheck", 64'(rc), 64'd1);
      check("R10 pending unchanged", 64'(pending), 64'h0);

      // R7 tick bit 63 ignored in match
      tick = 64'h8000_0000_0000_0258;
      wr(3'd3, 64'd605);
      run_to(64'h8000_0000_0000_025D);
      check("R7 low bits match", 64'(rc), 64'd1);
      check("R7 pending bit16", 64'(pending), 64'h10000);

      // R11 match and clear in the same cycle
      wr(3'd0, 64'h10001);
      tick = 64'd690;
      wr(3'd3, 64'd700);
      run_to(64'd699);
      tick = 64'd700;
      wr_en = 1'b1; addr = 3'd2; wr_data = 64'h10000;
      @(negedge clk);
      wr_en = 1'b0;
      check("R11 match over clear", 64'(pending), 64'h10001);
      check("R11 recheck", 64'(recheck), 64'h1);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule